// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Port

This block is the device-side logic that serves a one-time-programmable program store while the chip is in its programming mode. An external programmer has no address pins to work with. It selects one of four operations through a 4-bit mode input. It advances an internal byte pointer by toggling a single update-clock pin, and it moves bytes over an 8-bit data path. The path is split here into an input, an output and an output enable, which stand for the bidirectional bus.

Storage is organised as 16-bit words, and the programmer sees each word as two bytes: the upper half at an even byte address and the lower half at the odd address after it. The cells start erased to all ones. A program operation can only clear bits, so each write is a bitwise AND of the offered byte into the stored byte. The update clock and the mode code arrive from outside the system clock domain. Both are synchronised with two flops before any decoding or edge detection. Array depth is a parameter; a full-size part uses 12160 words.

Top module: `otp_prog_if`

## Requirements
- R1: After reset the output enable is low, the byte pointer and the pulse-group count are 0, and every stored byte reads as 8'hFF.
- R2: The mode code `mode_i` carries MD0 in bit 0 through MD3 in bit 3. 4'b0101 is clear, 4'b1110 is write, 4'b1100 is read/verify, and 4'b1101 or 4'b1111 is inhibit. `data_oe_o` is high only when the code seen three system clocks earlier was read/verify.
- R3: In read/verify, `data_o` shows the byte at the current pointer. Even pointers give bits 15:8 of word pointer/2, and odd pointers give bits 7:0.
- R4: Each entry into write mode performs one program of the byte at the pointer. The new value is the old value ANDed with `data_i`, so bits only ever go from 1 to 0.
- R5: Inhibit codes and undefined codes (for example 4'b0000) leave the bus released and change no stored byte, whatever `data_i` carries. `data_i` is also ignored in read/verify.
- R6: The pointer changes through the update clock only on the falling edge of the third pulse of each group of four pulses. Pulses are counted in every mode except clear.
- R7: While the clear code is applied, the pointer and the pulse-group count are forced to 0, and update-clock pulses have no effect.
- R8: The pointer saturates at the last byte location (2*WORDS-1) and never wraps to 0 through the update clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_clk_i | input | 1 | Asynchronous address-update clock from the programmer |
| mode_i | input | 4 | Asynchronous mode code, bit n = MDn |
| data_i | input | 8 | Byte offered by the programmer (bus input side) |
| data_o | output | 8 | Byte driven toward the programmer (bus output side) |
| data_oe_o | output | 1 | High when the block drives the bus, low when released |

## Verification
A small configuration of eight words (sixteen bytes) is filled with a distinct byte pattern and then read back through the whole range. Reading every location separates even from odd lane placement and proves the pointer steps exactly once per four pulses. Repeated writes of overlapping masks tell AND-merging apart from overwriting. Pulse sequences stopped at the second and third pulse, and sequences broken by a clear, locate the exact stepping edge and show that the group count restarts. Running well past the last byte exposes wrap against saturation, and inhibit, undefined and read-mode traffic with a zero data byte shows that nothing outside write mode programs a cell.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLEAR,
    OP_WRITE,
    OP_READ,
    OP_INHIBIT
  } otp_op_e;

  // mode code bit n corresponds to mode pin n
  function automatic otp_op_e decode_op(input logic [3:0] code);
    otp_op_e op;
    casez (code)
      4'b0101: op = OP_CLEAR;
      4'b1110: op = OP_WRITE;
      4'b1100: op = OP_READ;
      4'b11?1: op = OP_INHIBIT;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/otp_sync.sv
`timescale 1ns/1ps
module otp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end

endmodule

// File: rtl/otp_addr_seq.sv
`timescale 1ns/1ps
module otp_addr_seq #(
  parameter int AW   = 9,
  parameter int LAST = 511
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          upd_fall_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    phase_o
);

  localparam logic [AW-1:0] LAST_A  = AW'(LAST);
  localparam logic [1:0]    STEP_PH = 2'd2;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      addr_o  <= '0;
      phase_o <= '0;
    end else if (upd_fall_i) begin
      phase_o <= phase_o + 2'd1;
      if (phase_o == STEP_PH && addr_o != LAST_A) begin
        addr_o <= addr_o + AW'(1);
      end
    end
  end

endmodule

// File: rtl/otp_word_store.sv
`timescale 1ns/1ps
module otp_word_store #(
  parameter int WORDS = 256,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] byte_addr_i,
  input  logic          prog_go_i,
  input  logic [7:0]    prog_byte_i,
  output logic [7:0]    rd_byte_o
);

  localparam int WAW = AW - 1;

  logic [15:0] mem [WORDS];
  logic [15:0] rd_word_q;
  logic        lane_q;
  logic        go_d1;
  logic        go_d2;
  logic [7:0]  prog_q;
  logic [15:0] merged;

  wire [WAW-1:0] widx = byte_addr_i[AW-1:1];
  wire           lane = byte_addr_i[0];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
  end

  // lane 0 (even address) is the upper half, lane 1 the lower half
  always_comb begin
    if (lane) merged = {rd_word_q[15:8], rd_word_q[7:0] & prog_q};
    else      merged = {rd_word_q[15:8] & prog_q, rd_word_q[7:0]};
  end

  always_ff @(posedge clk) begin
    rd_word_q <= mem[widx];
    if (go_d2) mem[widx] <= merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_d1     <= 1'b0;
      go_d2     <= 1'b0;
      prog_q    <= 8'hFF;
      lane_q    <= 1'b0;
      rd_byte_o <= 8'h00;
    end else begin
      go_d1  <= prog_go_i;
      go_d2  <= go_d1;
      if (prog_go_i) prog_q <= prog_byte_i;
      lane_q    <= lane;
      rd_byte_o <= lane_q ? rd_word_q[7:0] : rd_word_q[15:8];
    end
  end

endmodule

// File: rtl/otp_prog_if.sv
`timescale 1ns/1ps
module otp_prog_if #(
  parameter int WORDS = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_clk_i,
  input  logic [3:0] mode_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o
);
  import otp_pkg::*;

  localparam int BYTES     = 2 * WORDS;
  localparam int AW        = $clog2(BYTES);
  localparam int LAST_BYTE = BYTES - 1;

  logic [4:0]    sync_q;
  logic          upd_s;
  logic [3:0]    mode_s;
  logic          upd_prev;
  logic          upd_fall;
  otp_op_e       op;
  logic          clr_s;
  logic          wr_s;
  logic          wr_prev;
  logic [AW-1:0] addr;
  logic [1:0]    phase;
  logic [7:0]    rd_byte;

  otp_sync #(.W(5)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({upd_clk_i, mode_i}),
    .q_o (sync_q)
  );

  assign upd_s  = sync_q[4];
  assign mode_s = sync_q[3:0];
  assign op     = decode_op(mode_s);
  assign clr_s  = (op == OP_CLEAR);
  assign wr_s   = (op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_prev <= 1'b0;
      wr_prev  <= 1'b0;
    end else begin
      upd_prev <= upd_s;
      wr_prev  <= wr_s;
    end
  end

  assign upd_fall = upd_prev & ~upd_s;

  otp_addr_seq #(.AW(AW), .LAST(LAST_BYTE)) i_addr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_s),
    .upd_fall_i (upd_fall),
    .addr_o     (addr),
    .phase_o    (phase)
  );

  otp_word_store #(.WORDS(WORDS), .AW(AW)) i_store (
    .clk         (clk),
    .rst         (rst),
    .byte_addr_i (addr),
    .prog_go_i   (wr_s & ~wr_prev),
    .prog_byte_i (data_i),
    .rd_byte_o   (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe_o <= 1'b0;
      data_o    <= 8'h00;
    end else begin
      data_oe_o <= (op == OP_READ);
      data_o    <= (op == OP_READ) ? rd_byte : 8'h00;
    end
  end

endmodule

// File: rtl/otp_prog_if_chk.sv
`timescale 1ns/1ps
module otp_prog_if_chk #(
  parameter int AW   = 9,
  parameter int LAST = 511
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    mode_i,
  input logic          data_oe_o,
  input logic [AW-1:0] addr,
  input logic [1:0]    phase,
  input logic          clr_s,
  input logic          upd_fall
);

  localparam logic [AW-1:0] LAST_A = AW'(LAST);

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> ($past(mode_i, 3) == 4'b1100)); // R2

  AST_STEP_ON_THIRD: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr) && addr != '0) |-> ($past(phase) == 2'd2 && $past(upd_fall))); // R6

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> (addr == '0 && phase == 2'd0)); // R7

  AST_ZERO_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (addr == '0 && $past(addr) != '0) |-> $past(clr_s)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST_A); // R8

endmodule

bind otp_prog_if otp_prog_if_chk #(.AW(AW), .LAST(LAST_BYTE)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_i    (mode_i),
  .data_oe_o (data_oe_o),
  .addr      (addr),
  .phase     (phase),
  .clr_s     (clr_s),
  .upd_fall  (upd_fall)
);

// File: tb/test_otp_prog_if.sv
`timescale 1ns/1ps
module test_otp_prog_if;

  localparam int WORDS = 8;
  localparam int BYTES = 2 * WORDS;
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_RD  = 4'b1100;
  localparam logic [3:0] M_INH = 4'b1101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] mem_m [BYTES];
  int addr_m = 0;
  int phase_m = 0;

  always #2.5 clk = ~clk;

  otp_prog_if #(.WORDS(WORDS)) i_otp_prog_if (
    .clk       (clk),
    .rst       (rst),
    .upd_clk_i (upd),
    .mode_i    (mode),
    .data_i    (din),
    .data_o    (dout),
    .data_oe_o (oe)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m;
    if (m == M_CLR) begin
      addr_m  = 0;
      phase_m = 0;
    end
    cyc(8);
  endtask

  task automatic pulse();
    upd = 1'b1;
    cyc(4);
    upd = 1'b0;
    if (mode != M_CLR) begin
      if (phase_m == 2 && addr_m < BYTES - 1) addr_m++;
      phase_m = (phase_m + 1) % 4;
    end
    cyc(8);
  endtask

  task automatic chk_rd(input logic [7:0] exp, input string tag);
    vectors++;
    if (!(oe === 1'b1 && dout === exp)) begin
      miscompares++;
      $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", tag, oe, dout, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    vectors++;
    if (oe !== 1'b0) begin
      miscompares++;
      $display("FAIL %s: oe=%b expected 0", tag, oe);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    set_mode(M_INH);
    din = d;
    set_mode(M_WR);
    set_mode(M_INH);
    mem_m[addr_m] = mem_m[addr_m] & d;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ 8'hA5);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BYTES; i++) mem_m[i] = 8'hFF;
    cyc(10);
    rst = 1'b0;
    cyc(4);
    chk_off("R1 reset releases bus");
    set_mode(M_RD);
    chk_rd(8'hFF, "R1 erased byte at pointer 0");

    // fill every byte with a distinct pattern, stepping in inhibit
    set_mode(M_CLR);
    chk_off("R2 clear releases bus");
    for (int a = 0; a < BYTES; a++) begin
      set_mode(M_INH);
      din = pat(a);
      set_mode(M_WR);
      if (a == 0) chk_off("R2 write releases bus");
      set_mode(M_INH);
      mem_m[addr_m] = mem_m[addr_m] & pat(a);
      for (int p = 0; p < 4; p++) pulse();
    end

    // read the whole range back, stepping in read mode
    set_mode(M_CLR);
    set_mode(M_RD);
    for (int a = 0; a < BYTES; a++) begin
      chk_rd(mem_m[addr_m], "R3 even/odd byte readback");
      for (int p = 0; p < 4; p++) pulse();
    end
    chk_rd(mem_m[BYTES-1], "R8 pointer held at last byte");
    for (int p = 0; p < 12; p++) pulse();
    chk_rd(mem_m[BYTES-1], "R8 no wrap after extra groups");

    // AND merge: repeated writes at pointers 0..3
    set_mode(M_CLR);
    for (int a = 0; a < 4; a++) begin
      wr_byte(8'h0F ^ 8'(a));
      wr_byte(8'hF3);
      for (int p = 0; p < 4; p++) pulse();
    end
    set_mode(M_CLR);
    set_mode(M_RD);
    for (int a = 0; a < 4; a++) begin
      chk_rd(mem_m[addr_m], "R4 AND merge of repeated writes");
      for (int p = 0; p < 4; p++) pulse();
    end

    // exact stepping edge
    set_mode(M_CLR);
    set_mode(M_RD);
    pulse();
    pulse();
    chk_rd(mem_m[0], "R6 no step after two pulses");
    upd = 1'b1;
    cyc(8);
    chk_rd(mem_m[0], "R6 no step on third rising edge");
    upd = 1'b0;
    phase_m = 3;
    addr_m = 1;
    cyc(8);
    chk_rd(mem_m[1], "R6 step on third falling edge");
    pulse();
    chk_rd(mem_m[1], "R6 no step on fourth pulse");
    for (int p = 0; p < 4; p++) pulse();
    chk_rd(mem_m[2], "R6 next group steps once");

    // clear restarts the group count and masks pulses
    set_mode(M_CLR);
    set_mode(M_RD);
    pulse();
    pulse();
    set_mode(M_CLR);
    for (int p = 0; p < 5; p++) pulse();
    set_mode(M_RD);
    chk_rd(mem_m[0], "R7 pulses ignored during clear");
    pulse();
    pulse();
    chk_rd(mem_m[0], "R7 count restarted after clear");
    pulse();
    chk_rd(mem_m[1], "R7 third pulse after clear steps");

    // inhibit, undefined and read modes never program
    for (int p = 0; p < 4; p++) pulse();
    din = 8'h00;
    set_mode(4'b1111);
    chk_off("R5 inhibit 1111 releases bus");
    set_mode(M_INH);
    chk_off("R5 inhibit 1101 releases bus");
    set_mode(4'b0000);
    chk_off("R5 undefined code releases bus");
    set_mode(M_RD);
    cyc(8);
    chk_rd(mem_m[addr_m], "R5 byte unchanged by zero data");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule